// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block drives a dual-slope integrating converter through its measurement cycle and counts the result. The oscillator is divided down to a count enable. Each count enable advances a cycle position counter that sets which of three analog phases is active. First comes a zeroing phase. Then the unknown input is integrated for a fixed time. Then the known reference winds the integrator back while a decimal counter runs. When the comparator reports that the integrator has crossed zero, the count is latched as the reading. If the comparator never crosses, the reading is pinned at the count limit and flagged as overrange.

The zeroing phase takes whatever part of the de-integrate window went unused. Every cycle therefore has the same length, whatever the input. With the default settings a cycle is 4000 counts, or 16000 oscillator clocks, so a 48 kHz oscillator gives three readings per second. The comparator is a digital input from an external analog stage. The integrator, the switches and the reference are outside this block.

Top module: `dual_slope_sequencer`

## Requirements
- R1: The phase counters advance only on a count enable, which fires once every PRESCALE (4) clocks. A count of N therefore lasts 4N clocks.
- R2: The signal integrate phase (`int_en_o` high) lasts exactly INT_COUNTS (1000) counts, which is 4000 clocks.
- R3: The comparator is passed through a two-flop synchronizer and read only on count enables during de-integrate. De-integrate ends on the first such read that sees it high. If that read is the (m+1)-th count enable of the phase, de-integrate has lasted m+1 counts and the result is m.
- R4: If no crossing is seen in DEINT_MAX (2000) counts, de-integrate ends after exactly 2000 counts. The result is then 2000 and `overrange_o` is set.
- R5: From one rise of `int_en_o` to the next is always CYCLE_COUNTS (4000) counts, which is 16000 clocks, whatever the comparator does.
- R6: The phases run in the order auto-zero, signal integrate, de-integrate, auto-zero. During reset the block is in auto-zero with the result 0 and no flags set. After reset the first auto-zero lasts 1000 counts (4000 clocks).
- R7: Exactly one of `az_en_o`, `int_en_o`, `deint_en_o` is high in every cycle out of reset.
- R8: The result is packed BCD, one 4-bit digit per decade, with the least significant decade in bits [3:0] (1234 reads as 16'h1234). It updates only in the clock where de-integrate ends. In that same clock `valid_o` is high, for one clock only, and the result then holds until the next reading.
- R9: The comparator has no effect during auto-zero or signal integrate. Holding it high there changes neither the phase lengths nor the latched result.
- R10: `overrange_o` is cleared by the next reading that ends on a comparator crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator output, high once the integrator has returned through zero |
| az_en_o | output | 1 | Auto-zero switch enable |
| int_en_o | output | 1 | Signal integrate switch enable |
| deint_en_o | output | 1 | Reference de-integrate switch enable |
| result_bcd_o | output | 4*DIGITS | Latched reading, packed BCD |
| overrange_o | output | 1 | Latched reading hit the count limit |
| valid_o | output | 1 | One-clock strobe when a new reading is latched |

## Verification
The comparator crossing is placed at several points in the de-integrate phase: the very first count, a few counts in, mid-range values with mixed digits, and the last count before the limit. This tests the count-to-result relation, digit carries across all four decades, and the boundary between the largest in-range reading and overrange. One run never raises the comparator, which exercises the limit path, and the run after it shows that the flag clears. Each run measures the integrate, de-integrate and whole-cycle lengths in clocks, so a wrong prescale, a wrong phase length, or an auto-zero that fails to absorb the leftover counts shows up as a wrong number. The comparator is held high across auto-zero and into signal integrate, which shows that it is ignored outside de-integrate.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   typedef enum logic [1:0] {
      PH_AZ    = 2'd0,
      PH_INT   = 2'd1,
      PH_DEINT = 2'd2
   } phase_e;

   // Binary to packed BCD, 16 decades at most, for elaboration-time constants.
   function automatic logic [63:0] bin2bcd(input int unsigned value);
      logic [63:0] packed_v;
      int unsigned rest;
      packed_v = '0;
      rest     = value;
      for (int d = 0; d < 16; d++) begin
         packed_v[d*4 +: 4] = 4'(rest % 10);
         rest               = rest / 10;
      end
      return packed_v;
   endfunction

endpackage

// File: rtl/dsq_prescaler.sv
module dsq_prescaler #(
   parameter int unsigned DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("dsq_prescaler: DIV must be at least 2");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);

   // A count enable is never followed directly by another one.
   assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/dsq_sync.sv
module dsq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dsq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsq_bcd_counter.sv
module dsq_bcd_counter #(
   parameter int unsigned DIGITS = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              inc_i,
   output logic [4*DIGITS-1:0] value_o
);
   logic [DIGITS:0] carry;
   assign carry[0] = inc_i;

   for (genvar d = 0; d < DIGITS; d++) begin : g_decade
      logic [3:0] dig_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) dig_q <= '0;
         else if (clr_i) dig_q <= '0;
         else if (carry[d]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
      end

      assign carry[d+1]        = carry[d] & (dig_q == 4'd9);
      assign value_o[d*4 +: 4] = dig_q;

      assert_digit_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         dig_q <= 4'd9);
   end

endmodule

// File: rtl/dual_slope_sequencer.sv
module dual_slope_sequencer #(
   parameter int unsigned PRESCALE     = 4,
   parameter int unsigned INT_COUNTS   = 1000,
   parameter int unsigned DEINT_MAX    = 2000,
   parameter int unsigned CYCLE_COUNTS = 4000,
   parameter int unsigned DIGITS       = 4,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cmp_i,
   output logic                az_en_o,
   output logic                int_en_o,
   output logic                deint_en_o,
   output logic [4*DIGITS-1:0] result_bcd_o,
   output logic                overrange_o,
   output logic                valid_o
);
   import dsq_pkg::*;

   localparam int unsigned CW = $clog2(CYCLE_COUNTS);
   localparam int unsigned BW = 4 * DIGITS;
   localparam logic [CW-1:0] INT_LAST  = CW'(INT_COUNTS - 1);
   localparam logic [CW-1:0] CYC_LAST  = CW'(CYCLE_COUNTS - 1);
   localparam logic [CW-1:0] AZ_RESET  = CW'(INT_COUNTS + DEINT_MAX);
   localparam logic [BW-1:0] LIM_BCD   = BW'(bin2bcd(DEINT_MAX));
   localparam logic [BW-1:0] LAST_BCD  = BW'(bin2bcd(DEINT_MAX - 1));

   // Elaboration-time parameter checks
   if (INT_COUNTS < 1 || DEINT_MAX < 1) begin : g_bad_len
      $error("dual_slope_sequencer: phase lengths must be nonzero");
   end
   if (INT_COUNTS + DEINT_MAX >= CYCLE_COUNTS) begin : g_bad_cycle
      $error("dual_slope_sequencer: cycle leaves no auto-zero time");
   end
   if (DIGITS < 1 || DIGITS > 16 || DEINT_MAX >= 10 ** DIGITS) begin : g_bad_digits
      $error("dual_slope_sequencer: DIGITS cannot hold DEINT_MAX");
   end

   logic tick;
   logic cmp_s;

   dsq_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   dsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_i),
      .q_o    (cmp_s)
   );

   logic          bcd_clr, bcd_inc;
   logic [BW-1:0] bcd_val;

   dsq_bcd_counter #(.DIGITS(DIGITS)) u_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (bcd_clr),
      .inc_i   (bcd_inc),
      .value_o (bcd_val)
   );

   phase_e        phase_q, phase_d;
   logic [CW-1:0] pos_q, pos_d;
   logic [BW-1:0] res_q, res_d;
   logic          ovr_q, ovr_d;
   logic          valid_q, valid_d;

   always_comb begin
      phase_d = phase_q;
      pos_d   = pos_q;
      res_d   = res_q;
      ovr_d   = ovr_q;
      valid_d = 1'b0;
      bcd_clr = 1'b0;
      bcd_inc = 1'b0;
      if (tick) begin
         pos_d = (pos_q == CYC_LAST) ? '0 : pos_q + 1'b1;
         unique case (phase_q)
            PH_AZ: begin
               if (pos_q == CYC_LAST) phase_d = PH_INT;
            end
            PH_INT: begin
               if (pos_q == INT_LAST) begin
                  phase_d = PH_DEINT;
                  bcd_clr = 1'b1;
               end
            end
            PH_DEINT: begin
               if (cmp_s) begin
                  phase_d = PH_AZ;
                  res_d   = bcd_val;
                  ovr_d   = 1'b0;
                  valid_d = 1'b1;
               end else if (bcd_val == LAST_BCD) begin
                  phase_d = PH_AZ;
                  res_d   = LIM_BCD;
                  ovr_d   = 1'b1;
                  valid_d = 1'b1;
               end else begin
                  bcd_inc = 1'b1;
               end
            end
            default: phase_d = PH_AZ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_AZ;
         pos_q   <= AZ_RESET;
         res_q   <= '0;
         ovr_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         pos_q   <= pos_d;
         res_q   <= res_d;
         ovr_q   <= ovr_d;
         valid_q <= valid_d;
      end
   end

   assign az_en_o      = (phase_q == PH_AZ);
   assign int_en_o     = (phase_q == PH_INT);
   assign deint_en_o   = (phase_q == PH_DEINT);
   assign result_bcd_o = res_q;
   assign overrange_o  = ovr_q;
   assign valid_o      = valid_q;

   assert_one_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({az_en_o, int_en_o, deint_en_o}) == 1);

   assert_valid_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (az_en_o && $past(deint_en_o)));

   assert_result_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(result_bcd_o));

   assert_ovr_is_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrange_o |-> (result_bcd_o == LIM_BCD));

   assert_deint_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deint_en_o |-> (bcd_val <= LAST_BCD));

   assert_int_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(int_en_o) |-> (pos_q == CW'(INT_COUNTS)));

   assert_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_en_o) |-> $past(az_en_o));

   assert_pos_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pos_q <= CYC_LAST);

endmodule

// File: tb/dual_slope_sequencer_bench.sv
module dual_slope_sequencer_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  LIMIT      = 2000;
   localparam int  NVEC       = 7;
   // Crossing position m per run (result m); LIMIT means the comparator never rises.
   localparam int  VEC [NVEC] = '{0, 9, 1234, 2000, 513, 1999, 99};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp = 1'b0;
   logic        az_en, int_en, deint_en, ovr, valid;
   logic [15:0] result;

   int    n_checks = 0;
   int    n_fail   = 0;
   int    onehot_bad = 0;
   longint cyc = 0;
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dual_slope_sequencer u_dual_slope_sequencer (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cmp_i        (cmp),
      .az_en_o      (az_en),
      .int_en_o     (int_en),
      .deint_en_o   (deint_en),
      .result_bcd_o (result),
      .overrange_o  (ovr),
      .valid_o      (valid)
   );

   always @(negedge clk)
      if (rst_n && ($countones({az_en, int_en, deint_en}) != 1)) onehot_bad++;

   function automatic logic [15:0] to_bcd(input int v);
      logic [15:0] r;
      int rest;
      rest = v;
      for (int d = 0; d < 4; d++) begin
         r[d*4 +: 4] = 4'(rest % 10);
         rest = rest / 10;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      longint t_rel, t_int, t_de, t_az, t_next;
      logic [15:0] held;

      repeat (4) @(posedge clk);
      @(negedge clk);
      // R6: reset state
      chk(az_en && !int_en && !deint_en, "R6", "reset phase", {az_en, int_en, deint_en}, 3'b100);
      chk(result == 16'h0 && !ovr && !valid, "R6", "reset result/flags",
          {ovr, valid, result}, 0);
      rst_n = 1'b1;
      t_rel = cyc;
      do @(negedge clk); while (!int_en);
      t_int = cyc;
      // R6/R1: first auto-zero is 1000 counts of 4 clocks
      chk(t_int - t_rel == 4000, "R6", "first auto-zero clocks", t_int - t_rel, 4000);

      for (int i = 0; i < NVEC; i++) begin
         int m;
         m = VEC[i];
         do @(negedge clk); while (!deint_en);
         t_de = cyc;
         chk(t_de - t_int == 4000, "R2", "integrate clocks", t_de - t_int, 4000);
         if (m < LIMIT) begin
            repeat (4*m + 1) @(posedge clk);
            @(negedge clk);
            cmp = 1'b1;
         end
         do @(negedge clk); while (!az_en);
         t_az = cyc;
         chk(valid == 1'b1, "R8", "valid at de-integrate end", valid, 1);
         if (m < LIMIT) begin
            chk(t_az - t_de == 4*(m+1), "R3", "de-integrate clocks", t_az - t_de, 4*(m+1));
            chk(result == to_bcd(m), "R3", "BCD result", result, to_bcd(m));
            chk(!ovr, "R10", "overrange clear on crossing", ovr, 0);
         end else begin
            chk(t_az - t_de == 8000, "R4", "limit de-integrate clocks", t_az - t_de, 8000);
            chk(result == 16'h2000, "R4", "limit result", result, 16'h2000);
            chk(ovr, "R4", "overrange flag", ovr, 1);
         end
         held = result;
         @(negedge clk);
         chk(!valid, "R8", "valid one clock", valid, 0);
         do @(negedge clk); while (!int_en);
         t_next = cyc;
         chk(t_next - t_int == 16000, "R5", "cycle clocks", t_next - t_int, 16000);
         t_int = t_next;
         // R9: comparator held high across auto-zero, still high into integrate
         repeat (100) @(negedge clk);
         chk(int_en && result == held, "R9", "comparator ignored in integrate",
             {int_en, result}, {1'b1, held});
         cmp = 1'b0;
      end

      chk(onehot_bad == 0, "R7", "one-hot phase cycles violated", onehot_bad, 0);
      finish_run();
   end

endmodule